// File: doc/BRIEF.md
# Variable-Page Associative Address Translator

This block is a fully associative address translation buffer with a parameterised number of entries (64 by default). A 32-bit virtual address is compared against every entry in parallel. Each entry has its own page size, so every entry uses its own compare mask. An address-space tag takes part in the match unless the entry is marked shared, or unless the requester is privileged while the single-address-space mode input is set. The block returns the translated physical address, the index of the matching entry, that entry's protection and dirty bits, and a status of hit, miss or multiple hit. It decides the status by counting how many entries match.

Software loads entries through a one-entry-per-cycle write port. A lookup is requested with a one-cycle strobe, and the registered response appears on the next clock edge. A victim-selection counter advances on every lookup and returns to zero when it reaches a programmable bound. The block does not walk page tables, deliver exceptions or access memory.

Top module: `tlb_assoc_lookup`

## Requirements
- R1: After reset every entry is invalid, `rsp_valid_o` is 0 and `repl_cnt_o` is 0, so the first lookup reports a miss.
- R2: The entry size code sets the compare mask. Code 0 compares VA[31:10], code 1 compares VA[31:12], code 2 compares VA[31:16] and code 3 compares VA[31:20]. An address one byte beyond the page misses.
- R3: On a hit, the physical address is ({PPN,10'b0} ANDed with the page mask) ORed with the virtual-address bits below the mask. PPN bits below the page size have no effect.
- R4: An entry whose valid bit is 0 never matches.
- R5: A non-shared entry matches only when its tag equals `cur_asid_i`, unless R7 applies.
- R6: A shared entry matches whatever the value of `cur_asid_i`.
- R7: When `priv_i` and `single_vm_i` are both 1, the tag is ignored. When only one of them is 1, the tag still takes part in the match.
- R8: `rsp_status_o` is 2'b00 when no entry matches, 2'b01 when exactly one entry matches and 2'b10 when two or more match. On a multiple hit, `rsp_hit_idx_o` is the lowest matching index, and `rsp_pa_o`, `rsp_prot_o` and `rsp_dirty_o` are 0. On a miss, all four outputs are 0.
- R9: A strobe on `lkup_req_i` sampled at one clock edge gives `rsp_valid_o` = 1 with the result after that edge, for exactly one cycle.
- R10: A write takes effect at the edge where `wr_en_i` is sampled. A lookup sampled at that same edge still sees the old contents. A lookup sampled at the next edge sees the new contents.
- R11: Each lookup changes `repl_cnt_o` to `repl_cnt_o + 1` (modulo 2^IDX_W). When that value equals `repl_bound_i`, the counter becomes 0 instead. Without a lookup the counter holds.
- R12: On a single hit, `rsp_hit_idx_o`, `rsp_prot_o` and `rsp_dirty_o` come from the matching entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Entry write strobe |
| wr_idx_i | input | IDX_W | Entry index to write |
| wr_vpn_i | input | 22 | Virtual page number, VA[31:10] |
| wr_asid_i | input | 8 | Address-space tag |
| wr_ppn_i | input | 22 | Physical page number, PA[31:10] |
| wr_size_i | input | 2 | Page size code |
| wr_valid_i | input | 1 | Entry valid |
| wr_shared_i | input | 1 | Shared page (tag ignored) |
| wr_prot_i | input | 2 | Protection bits, returned on hit |
| wr_dirty_i | input | 1 | Dirty bit, returned on hit |
| lkup_req_i | input | 1 | Lookup strobe |
| lkup_va_i | input | 32 | Virtual address to translate |
| cur_asid_i | input | 8 | Current address-space tag |
| priv_i | input | 1 | Requester is privileged |
| single_vm_i | input | 1 | Single-address-space mode |
| repl_bound_i | input | IDX_W | Wrap bound of the replacement counter |
| rsp_valid_o | output | 1 | Response valid, one cycle |
| rsp_status_o | output | 2 | 00 miss, 01 hit, 10 multiple hit |
| rsp_hit_idx_o | output | IDX_W | Matching entry index |
| rsp_pa_o | output | 32 | Translated physical address |
| rsp_prot_o | output | 2 | Protection bits of the hit entry |
| rsp_dirty_o | output | 1 | Dirty bit of the hit entry |
| repl_cnt_o | output | IDX_W | Replacement counter |

## Verification
The hardest situation to reach from the ports is a lookup that coincides with a write to the entry it would hit. The bench reaches it by driving `wr_en_i` and `lkup_req_i` in the same cycle and expecting the old contents (a miss), then looking up again one cycle later and expecting a hit. The multiple-hit path needs two valid entries that cover one address. The bench programs two shared entries with the same page, checks that the lower index is reported, then invalidates that entry and expects a single hit on the other. The replacement-counter wrap is reached by setting the bound a few steps ahead of the counter value the bench models, then checking every step.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int VA_W       = 32;
  localparam int PAGE_SHIFT = 10;
  localparam int VPN_W      = VA_W - PAGE_SHIFT;
  localparam int PPN_W      = VA_W - PAGE_SHIFT;
  localparam int ASID_W     = 8;
  localparam int ATTR_W     = 3;

  typedef struct packed {
    logic [VPN_W-1:0]  vpn;
    logic [ASID_W-1:0] asid;
    logic [PPN_W-1:0]  ppn;
    logic [1:0]        size;
    logic              valid;
    logic              shared;
    logic [1:0]        prot;
    logic              dirty;
  } tlb_entry_t;

  typedef enum logic [1:0] {
    ST_MISS  = 2'b00,
    ST_HIT   = 2'b01,
    ST_MULTI = 2'b10
  } lk_status_e;

  function automatic logic [VA_W-1:0] page_mask(input logic [1:0] sz);
    case (sz)
      2'd0:    page_mask = ~32'h0000_03FF;
      2'd1:    page_mask = ~32'h0000_0FFF;
      2'd2:    page_mask = ~32'h0000_FFFF;
      default: page_mask = ~32'h000F_FFFF;
    endcase
  endfunction
endpackage

// File: rtl/tlb_entry_store.sv
module tlb_entry_store
  import tlb_pkg::*;
#(
  parameter int N_ENTRIES = 64,
  parameter int IDX_W     = $clog2(N_ENTRIES)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          wr_en_i,
  input  logic [IDX_W-1:0]              wr_idx_i,
  input  tlb_entry_t                    wr_entry_i,
  output tlb_entry_t [N_ENTRIES-1:0]    entries_o
);
  for (genvar g = 0; g < N_ENTRIES; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        entries_o[g] <= '0;
      else if (wr_en_i && (wr_idx_i == IDX_W'(g)))
        entries_o[g] <= wr_entry_i;
    end
  end
endmodule

// File: rtl/tlb_match_array.sv
module tlb_match_array
  import tlb_pkg::*;
#(
  parameter int N_ENTRIES = 64
) (
  input  tlb_entry_t [N_ENTRIES-1:0]             entries_i,
  input  logic [VA_W-1:0]                        va_i,
  input  logic [ASID_W-1:0]                      cur_asid_i,
  input  logic                                   priv_i,
  input  logic                                   single_vm_i,
  output logic [N_ENTRIES-1:0]                   match_o,
  output logic [N_ENTRIES-1:0][VA_W-1:0]         pa_o,
  output logic [N_ENTRIES-1:0][ATTR_W-1:0]       attr_o
);
  logic asid_global;
  assign asid_global = priv_i & single_vm_i;

  for (genvar g = 0; g < N_ENTRIES; g++) begin : g_cmp
    logic [VA_W-1:0] mask;
    logic [VA_W-1:0] vbase;
    logic [VA_W-1:0] pbase;
    logic            addr_eq;
    logic            asid_ok;

    assign mask    = page_mask(entries_i[g].size);
    assign vbase   = {entries_i[g].vpn, {PAGE_SHIFT{1'b0}}};
    assign pbase   = {entries_i[g].ppn, {PAGE_SHIFT{1'b0}}};
    assign addr_eq = ((vbase ^ va_i) & mask) == '0;
    assign asid_ok = entries_i[g].shared | asid_global |
                     (entries_i[g].asid == cur_asid_i);
    assign match_o[g] = entries_i[g].valid & addr_eq & asid_ok;
    assign pa_o[g]    = (pbase & mask) | (va_i & ~mask);
    assign attr_o[g]  = {entries_i[g].prot, entries_i[g].dirty};
  end
endmodule

// File: rtl/tlb_resolve.sv
module tlb_resolve
  import tlb_pkg::*;
#(
  parameter int N_ENTRIES = 64,
  parameter int IDX_W     = $clog2(N_ENTRIES)
) (
  input  logic [N_ENTRIES-1:0]               match_i,
  input  logic [N_ENTRIES-1:0][VA_W-1:0]     pa_i,
  input  logic [N_ENTRIES-1:0][ATTR_W-1:0]   attr_i,
  output lk_status_e                         status_o,
  output logic [IDX_W-1:0]                   idx_o,
  output logic [VA_W-1:0]                    pa_o,
  output logic [ATTR_W-1:0]                  attr_o
);
  localparam int CNT_W = $clog2(N_ENTRIES + 1);

  logic [CNT_W-1:0] hit_cnt;
  logic [IDX_W-1:0] first;
  logic             single;

  always_comb begin
    hit_cnt = '0;
    for (int i = 0; i < N_ENTRIES; i++)
      hit_cnt = hit_cnt + CNT_W'(match_i[i]);
  end

  // lowest matching index wins
  always_comb begin
    first = '0;
    for (int i = N_ENTRIES - 1; i >= 0; i--)
      if (match_i[i]) first = IDX_W'(i);
  end

  assign single = (hit_cnt == CNT_W'(1));

  always_comb begin
    if (hit_cnt == '0)  status_o = ST_MISS;
    else if (single)    status_o = ST_HIT;
    else                status_o = ST_MULTI;
  end

  assign idx_o  = first;
  assign pa_o   = single ? pa_i[first]   : '0;
  assign attr_o = single ? attr_i[first] : '0;
endmodule

// File: rtl/tlb_repl_counter.sv
module tlb_repl_counter #(
  parameter int IDX_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  input  logic [IDX_W-1:0] bound_i,
  output logic [IDX_W-1:0] cnt_o
);
  logic [IDX_W-1:0] inc;
  assign inc = cnt_o + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)
      cnt_o <= '0;
    else if (step_i)
      cnt_o <= (inc == bound_i) ? '0 : inc;
  end
endmodule

// File: rtl/tlb_assoc_lookup.sv
module tlb_assoc_lookup
  import tlb_pkg::*;
#(
  parameter int N_ENTRIES = 64,
  localparam int IDX_W    = $clog2(N_ENTRIES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [21:0]       wr_vpn_i,
  input  logic [7:0]        wr_asid_i,
  input  logic [21:0]       wr_ppn_i,
  input  logic [1:0]        wr_size_i,
  input  logic              wr_valid_i,
  input  logic              wr_shared_i,
  input  logic [1:0]        wr_prot_i,
  input  logic              wr_dirty_i,
  input  logic              lkup_req_i,
  input  logic [31:0]       lkup_va_i,
  input  logic [7:0]        cur_asid_i,
  input  logic              priv_i,
  input  logic              single_vm_i,
  input  logic [IDX_W-1:0]  repl_bound_i,
  output logic              rsp_valid_o,
  output logic [1:0]        rsp_status_o,
  output logic [IDX_W-1:0]  rsp_hit_idx_o,
  output logic [31:0]       rsp_pa_o,
  output logic [1:0]        rsp_prot_o,
  output logic              rsp_dirty_o,
  output logic [IDX_W-1:0]  repl_cnt_o
);
  tlb_entry_t                           wr_entry;
  tlb_entry_t [N_ENTRIES-1:0]           entries;
  logic [N_ENTRIES-1:0]                 match;
  logic [N_ENTRIES-1:0][VA_W-1:0]       pa_all;
  logic [N_ENTRIES-1:0][ATTR_W-1:0]     attr_all;
  lk_status_e                           status;
  logic [IDX_W-1:0]                     idx;
  logic [VA_W-1:0]                      pa;
  logic [ATTR_W-1:0]                    attr;

  always_comb begin
    wr_entry        = '0;
    wr_entry.vpn    = wr_vpn_i;
    wr_entry.asid   = wr_asid_i;
    wr_entry.ppn    = wr_ppn_i;
    wr_entry.size   = wr_size_i;
    wr_entry.valid  = wr_valid_i;
    wr_entry.shared = wr_shared_i;
    wr_entry.prot   = wr_prot_i;
    wr_entry.dirty  = wr_dirty_i;
  end

  tlb_entry_store #(.N_ENTRIES(N_ENTRIES), .IDX_W(IDX_W)) u_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_idx_i   (wr_idx_i),
    .wr_entry_i (wr_entry),
    .entries_o  (entries)
  );

  tlb_match_array #(.N_ENTRIES(N_ENTRIES)) u_match (
    .entries_i   (entries),
    .va_i        (lkup_va_i),
    .cur_asid_i  (cur_asid_i),
    .priv_i      (priv_i),
    .single_vm_i (single_vm_i),
    .match_o     (match),
    .pa_o        (pa_all),
    .attr_o      (attr_all)
  );

  tlb_resolve #(.N_ENTRIES(N_ENTRIES), .IDX_W(IDX_W)) u_resolve (
    .match_i  (match),
    .pa_i     (pa_all),
    .attr_i   (attr_all),
    .status_o (status),
    .idx_o    (idx),
    .pa_o     (pa),
    .attr_o   (attr)
  );

  tlb_repl_counter #(.IDX_W(IDX_W)) u_repl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .step_i  (lkup_req_i),
    .bound_i (repl_bound_i),
    .cnt_o   (repl_cnt_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o   <= 1'b0;
      rsp_status_o  <= ST_MISS;
      rsp_hit_idx_o <= '0;
      rsp_pa_o      <= '0;
      rsp_prot_o    <= '0;
      rsp_dirty_o   <= 1'b0;
    end else begin
      rsp_valid_o <= lkup_req_i;
      if (lkup_req_i) begin
        rsp_status_o  <= status;
        rsp_hit_idx_o <= (status == ST_MISS) ? '0 : idx;
        rsp_pa_o      <= pa;
        rsp_prot_o    <= attr[2:1];
        rsp_dirty_o   <= attr[0];
      end
    end
  end
endmodule

// File: rtl/tlb_assoc_lookup_chk.sv
module tlb_assoc_lookup_chk #(
  parameter int IDX_W = 6
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             lkup_req_i,
  input logic [31:0]      lkup_va_i,
  input logic [IDX_W-1:0] repl_bound_i,
  input logic             rsp_valid_o,
  input logic [1:0]       rsp_status_o,
  input logic [IDX_W-1:0] rsp_hit_idx_o,
  input logic [31:0]      rsp_pa_o,
  input logic [1:0]       rsp_prot_o,
  input logic             rsp_dirty_o,
  input logic [IDX_W-1:0] repl_cnt_o
);
  p_rsp_after_req_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lkup_req_i |=> rsp_valid_o);

  p_no_rsp_without_req_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lkup_req_i |=> !rsp_valid_o);

  p_status_legal_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> (rsp_status_o != 2'b11));

  p_miss_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_status_o == 2'b00) |->
      (rsp_pa_o == '0 && rsp_prot_o == '0 && !rsp_dirty_o && rsp_hit_idx_o == '0));

  p_offset_kept_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lkup_req_i |=> (rsp_status_o != 2'b01) || (rsp_pa_o[9:0] == $past(lkup_va_i[9:0])));

  p_cnt_step_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lkup_req_i && (IDX_W'(repl_cnt_o + 1'b1) != repl_bound_i)) |=>
      (repl_cnt_o == IDX_W'($past(repl_cnt_o) + 1'b1)));

  p_cnt_wrap_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lkup_req_i && (IDX_W'(repl_cnt_o + 1'b1) == repl_bound_i)) |=> (repl_cnt_o == '0));

  p_cnt_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lkup_req_i |=> $stable(repl_cnt_o));
endmodule

bind tlb_assoc_lookup tlb_assoc_lookup_chk #(.IDX_W(IDX_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .lkup_req_i    (lkup_req_i),
  .lkup_va_i     (lkup_va_i),
  .repl_bound_i  (repl_bound_i),
  .rsp_valid_o   (rsp_valid_o),
  .rsp_status_o  (rsp_status_o),
  .rsp_hit_idx_o (rsp_hit_idx_o),
  .rsp_pa_o      (rsp_pa_o),
  .rsp_prot_o    (rsp_prot_o),
  .rsp_dirty_o   (rsp_dirty_o),
  .repl_cnt_o    (repl_cnt_o)
);

// File: tb/tlb_assoc_lookup_tb_top.sv
module tlb_assoc_lookup_tb_top;
  localparam int IDX_W = 6;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              wr_en_i = 1'b0;
  logic [IDX_W-1:0]  wr_idx_i = '0;
  logic [21:0]       wr_vpn_i = '0;
  logic [7:0]        wr_asid_i = '0;
  logic [21:0]       wr_ppn_i = '0;
  logic [1:0]        wr_size_i = '0;
  logic              wr_valid_i = 1'b0;
  logic              wr_shared_i = 1'b0;
  logic [1:0]        wr_prot_i = '0;
  logic              wr_dirty_i = 1'b0;
  logic              lkup_req_i = 1'b0;
  logic [31:0]       lkup_va_i = '0;
  logic [7:0]        cur_asid_i = '0;
  logic              priv_i = 1'b0;
  logic              single_vm_i = 1'b0;
  logic [IDX_W-1:0]  repl_bound_i = '0;
  logic              rsp_valid_o;
  logic [1:0]        rsp_status_o;
  logic [IDX_W-1:0]  rsp_hit_idx_o;
  logic [31:0]       rsp_pa_o;
  logic [1:0]        rsp_prot_o;
  logic              rsp_dirty_o;
  logic [IDX_W-1:0]  repl_cnt_o;

  int n_run  = 0;
  int n_fail = 0;
  logic [IDX_W-1:0] exp_cnt = '0;

  localparam logic [1:0] MISS = 2'b00, HIT = 2'b01, MULTI = 2'b10;

  always #10 clk_i = ~clk_i;

  tlb_assoc_lookup dut_i (.*);

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic step_model();
    logic [IDX_W-1:0] nx;
    nx = exp_cnt + 1'b1;
    exp_cnt = (nx == repl_bound_i) ? '0 : nx;
  endtask

  task automatic wr(input int idx, input logic [21:0] vpn, input logic [7:0] asid,
                    input logic [21:0] ppn, input logic [1:0] sz, input logic v,
                    input logic sh, input logic [1:0] pr, input logic d);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_idx_i = IDX_W'(idx); wr_vpn_i = vpn; wr_asid_i = asid;
    wr_ppn_i = ppn; wr_size_i = sz; wr_valid_i = v; wr_shared_i = sh;
    wr_prot_i = pr; wr_dirty_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic look(input logic [31:0] va);
    @(negedge clk_i);
    lkup_req_i = 1'b1; lkup_va_i = va;
    @(negedge clk_i);
    lkup_req_i = 1'b0;
    step_model();
  endtask

  task automatic t_reset();
    chk("R1 valid", 32'(rsp_valid_o), 0);
    chk("R1 cnt", 32'(repl_cnt_o), 0);
    look(32'h0000_0000);
    chk("R1 first lookup miss", 32'(rsp_status_o), 32'(MISS));
  endtask

  task automatic t_sizes();
    cur_asid_i = 8'd0;
    wr(1, 22'h080000, 8'd0, 22'h100000, 2'd0, 1'b1, 1'b0, 2'd0, 1'b0);
    look(32'h2000_03FC); chk("R2 1K hit", 32'(rsp_status_o), 32'(HIT));
    chk("R3 1K pa", rsp_pa_o, 32'h4000_03FC);
    look(32'h2000_0400); chk("R2 1K edge miss", 32'(rsp_status_o), 32'(MISS));
    wr(1, 22'h080000, 8'd0, 22'h100000, 2'd1, 1'b1, 1'b0, 2'd0, 1'b0);
    look(32'h2000_0FFC); chk("R2 4K hit", 32'(rsp_status_o), 32'(HIT));
    chk("R3 4K pa", rsp_pa_o, 32'h4000_0FFC);
    look(32'h2000_1000); chk("R2 4K edge miss", 32'(rsp_status_o), 32'(MISS));
    wr(1, 22'h080000, 8'd0, 22'h100000, 2'd2, 1'b1, 1'b0, 2'd0, 1'b0);
    look(32'h2000_FFF0); chk("R2 64K hit", 32'(rsp_status_o), 32'(HIT));
    chk("R3 64K pa", rsp_pa_o, 32'h4000_FFF0);
    look(32'h2001_0000); chk("R2 64K edge miss", 32'(rsp_status_o), 32'(MISS));
    // low VPN/PPN bits below a 1 MB page are ignored
    wr(1, 22'h080003, 8'd0, 22'h100005, 2'd3, 1'b1, 1'b0, 2'd0, 1'b0);
    look(32'h200F_FFF0); chk("R2 1M hit", 32'(rsp_status_o), 32'(HIT));
    chk("R3 1M pa masks ppn", rsp_pa_o, 32'h400F_FFF0);
    look(32'h2010_0000); chk("R2 1M edge miss", 32'(rsp_status_o), 32'(MISS));
  endtask

  task automatic t_asid();
    wr(2, 22'h0C0000, 8'd7, 22'h140000, 2'd1, 1'b1, 1'b0, 2'd0, 1'b0);
    cur_asid_i = 8'd7; priv_i = 1'b0; single_vm_i = 1'b0;
    look(32'h3000_0010); chk("R5 tag equal hit", 32'(rsp_status_o), 32'(HIT));
    chk("R3 pa", rsp_pa_o, 32'h5000_0010);
    cur_asid_i = 8'd8;
    look(32'h3000_0010); chk("R5 tag differs miss", 32'(rsp_status_o), 32'(MISS));
    priv_i = 1'b1; single_vm_i = 1'b1;
    look(32'h3000_0010); chk("R7 priv+single hit", 32'(rsp_status_o), 32'(HIT));
    single_vm_i = 1'b0;
    look(32'h3000_0010); chk("R7 priv only miss", 32'(rsp_status_o), 32'(MISS));
    priv_i = 1'b0; single_vm_i = 1'b1;
    look(32'h3000_0010); chk("R7 single only miss", 32'(rsp_status_o), 32'(MISS));
    single_vm_i = 1'b0;
    wr(2, 22'h0C0000, 8'd7, 22'h140000, 2'd1, 1'b1, 1'b1, 2'd0, 1'b0);
    look(32'h3000_0010); chk("R6 shared hit", 32'(rsp_status_o), 32'(HIT));
    cur_asid_i = 8'd7;
    wr(2, 22'h0C0000, 8'd7, 22'h140000, 2'd1, 1'b0, 1'b0, 2'd0, 1'b0);
    look(32'h3000_0010); chk("R4 invalid miss", 32'(rsp_status_o), 32'(MISS));
    chk("R8 miss pa zero", rsp_pa_o, 32'h0);
  endtask

  task automatic t_multi();
    cur_asid_i = 8'd0;
    wr(9, 22'h180000, 8'd3, 22'h0C0000, 2'd1, 1'b1, 1'b1, 2'd2, 1'b1);
    wr(5, 22'h180000, 8'd3, 22'h0C4000, 2'd1, 1'b1, 1'b1, 2'd1, 1'b0);
    look(32'h6000_0020); chk("R8 multi status", 32'(rsp_status_o), 32'(MULTI));
    chk("R8 multi lowest idx", 32'(rsp_hit_idx_o), 5);
    chk("R8 multi pa zero", rsp_pa_o, 32'h0);
    wr(5, 22'h180000, 8'd3, 22'h0C4000, 2'd1, 1'b0, 1'b1, 2'd1, 1'b0);
    look(32'h6000_0020); chk("R8 single after inval", 32'(rsp_status_o), 32'(HIT));
    chk("R12 idx", 32'(rsp_hit_idx_o), 9);
    chk("R12 prot", 32'(rsp_prot_o), 2);
    chk("R12 dirty", 32'(rsp_dirty_o), 1);
    chk("R3 pa", rsp_pa_o, 32'h3000_0020);
  endtask

  task automatic t_timing();
    look(32'h6000_0020);
    chk("R9 valid after req", 32'(rsp_valid_o), 1);
    @(negedge clk_i);
    chk("R9 single cycle pulse", 32'(rsp_valid_o), 0);
    // write and lookup sampled at the same edge
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_idx_i = 6'd11; wr_vpn_i = 22'h1C0000; wr_asid_i = 8'd0;
    wr_ppn_i = 22'h000400; wr_size_i = 2'd1; wr_valid_i = 1'b1; wr_shared_i = 1'b1;
    wr_prot_i = 2'd3; wr_dirty_i = 1'b0;
    lkup_req_i = 1'b1; lkup_va_i = 32'h7000_0044;
    @(negedge clk_i);
    wr_en_i = 1'b0; lkup_req_i = 1'b0;
    step_model();
    chk("R10 same edge old contents", 32'(rsp_status_o), 32'(MISS));
    look(32'h7000_0044);
    chk("R10 next edge new contents", 32'(rsp_status_o), 32'(HIT));
    chk("R10 pa", rsp_pa_o, 32'h0010_0044);
    chk("R12 idx 11", 32'(rsp_hit_idx_o), 11);
  endtask

  task automatic t_counter();
    chk("R11 model before", 32'(repl_cnt_o), 32'(exp_cnt));
    repl_bound_i = IDX_W'(exp_cnt + 3);
    for (int k = 0; k < 8; k++) begin
      look(32'h0000_1000);
      chk("R11 step", 32'(repl_cnt_o), 32'(exp_cnt));
    end
    repeat (3) @(negedge clk_i);
    chk("R11 hold", 32'(repl_cnt_o), 32'(exp_cnt));
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_sizes();
    t_asid();
    t_multi();
    t_timing();
    t_counter();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    n_run++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule